// File: doc/BRIEF.md
# Floating-Point Status and Trap Controller

This block holds the status/control word that sits beside a floating-point datapath. Software loads it through a write port; the arithmetic unit, which lives elsewhere, reports five raw exception indications at the end of every operation. The block records those indications in a flag field and accumulates them into a cause field. It requests an exception when a recorded cause is also enabled.

The control side of the word is decoded continuously. A two-bit mode field selects truncation toward zero or round-to-nearest-even. A single bit turns on flushing of denormal values. Both are driven out as plain levels to the datapath.

Compare operations are treated in a particular way. An ordered compare result (equal, greater or less) leaves the word alone. Only an unordered compare takes the same update path as an arithmetic operation.

Top module: `fpsr_unit`

## Requirements
- R1: After reset the status word reads 0 and no trap is requested. A write stores `wr_data` masked to bits 18:0, and bits 31:19 always read 0.
- R2: `rnd_zero` is 1 exactly when bits 1:0 of the word hold 2'b01. Any other code, including 2'b00, 2'b10 and 2'b11, gives 0 (round to nearest even).
- R3: `flush_zero` follows bit 18 of the word.
- R4: An applied operation replaces the flag field, bits 6:2, with `exc_flags`. Bit position 2+k takes `exc_flags[k]`, where k=0 is invalid, 1 is divide-by-zero, 2 is overflow, 3 is underflow and 4 is inexact. The field is cleared when all indications are 0.
- R5: An applied operation with at least one indication set ORs `exc_flags[k]` into cause bit 12+k. With no indication set, the cause field (bits 17:12) is unchanged. Cause bit 17 is never set by an operation.
- R6: The clock edge that updates the word for an applied operation also sets `trap_req` high for one cycle, but only if that operation reported at least one indication and the new cause bits 16:12 share a set bit with the enable bits 11:7 (enable bit 7+k matches indication k). `trap_req` is 0 in every other cycle, and `trap_code` reads 12'h120.
- R7: A compare operation (`op_is_cmp`=1) with `cmp_unordered`=0 leaves the word unchanged and raises no trap. A compare with `cmp_unordered`=1 is applied like any other operation.
- R8: When a write and an applied operation fall in the same cycle, the operation's update is made on top of the masked written value, and the trap test uses the written enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load the status word from `wr_data` |
| wr_data | input | 32 | Value to load (masked) |
| op_done | input | 1 | One-cycle strobe: an FP operation has finished |
| op_is_cmp | input | 1 | The finished operation was a compare |
| cmp_unordered | input | 1 | The compare result was unordered |
| exc_flags | input | 5 | Raw indications: [0] invalid, [1] div-by-zero, [2] overflow, [3] underflow, [4] inexact |
| csr_q | output | 32 | Current status word |
| rnd_zero | output | 1 | 1: truncate toward zero; 0: round to nearest even |
| flush_zero | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | One-cycle exception request |
| trap_code | output | 12 | Exception vector code, 12'h120 |

## Verification
A software load and an operation-end update can land on the same clock edge. That is the collision that matters here. The bench drives `wr_en` and `op_done` together in one cycle: once with a written value that enables the reported indication, and once with a value that clears an enable the old word had set. The outcome is judged on the word read after that edge. It must hold the written control bits with the operation's flags and cause merged in, and `trap_req` must follow the written enables, not the old ones.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int CSR_W       = 32;
    localparam int NFLAG       = 5;
    localparam int RM_W        = 2;
    localparam int CAUSE_W     = NFLAG + 1;
    localparam int USED_W      = RM_W + NFLAG + NFLAG + CAUSE_W + 1;
    localparam int PAD_W       = CSR_W - USED_W;
    localparam int TRAP_CODE_W = 12;

    localparam logic [RM_W-1:0]        RM_TO_ZERO = 2'b01;
    localparam logic [TRAP_CODE_W-1:0] TRAP_VEC   = 12'h120;

    typedef logic [NFLAG-1:0] fexc_t;

    typedef enum logic {
        RND_NEAREST = 1'b0,
        RND_ZERO    = 1'b1
    } rnd_e;

    // Word layout, MSB first: pad | dn | cause | enable | flags | rm
    typedef struct packed {
        logic [PAD_W-1:0]   pad;
        logic               dn;
        logic [CAUSE_W-1:0] cause;
        fexc_t              en;
        fexc_t              flags;
        logic [RM_W-1:0]    rm;
    } fpsr_t;

    function automatic logic [CSR_W-1:0] writable_mask();
        logic [CSR_W-1:0] m;
        m = '0;
        for (int i = 0; i < USED_W; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic rnd_e decode_rm(logic [RM_W-1:0] rm);
        return (rm == RM_TO_ZERO) ? RND_ZERO : RND_NEAREST;
    endfunction

endpackage

// File: rtl/fpsr_reg.sv
module fpsr_reg
    import fpsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             op_apply,
    input  fexc_t            exc,
    output fpsr_t            cur,
    output logic             trap_hit
);
    localparam logic [CSR_W-1:0] WMASK = writable_mask();

    fpsr_t base;
    fpsr_t nxt;

    always_comb begin
        base = wr_en ? fpsr_t'(wr_data & WMASK) : cur;
        nxt  = base;
        if (op_apply) begin
            nxt.flags = exc;
            if (|exc)
                nxt.cause[NFLAG-1:0] = base.cause[NFLAG-1:0] | exc;
        end
    end

    assign trap_hit = op_apply && (|exc) && (|(nxt.cause[NFLAG-1:0] & nxt.en));

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assert_pad_zero_R1: assert property (@(posedge clk) disable iff (rst)
        cur.pad == '0);

    assert_flags_load_R4: assert property (@(posedge clk) disable iff (rst)
        op_apply |=> cur.flags == $past(exc));

    assert_cause_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (op_apply && exc == '0 && !wr_en) |=> $stable(cur.cause));

    assert_cause_top_R5: assert property (@(posedge clk) disable iff (rst)
        (op_apply && !wr_en) |=> cur.cause[CAUSE_W-1] == $past(cur.cause[CAUSE_W-1]));

endmodule

// File: rtl/fpsr_trap.sv
module fpsr_trap
    import fpsr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   hit,
    output logic                   trap_req,
    output logic [TRAP_CODE_W-1:0] trap_code
);
    always_ff @(posedge clk) begin
        if (rst) trap_req <= 1'b0;
        else     trap_req <= hit;
    end

    assign trap_code = TRAP_VEC;

    assert_trap_after_hit_R6: assert property (@(posedge clk) disable iff (rst)
        !hit |=> !trap_req);
endmodule

// File: rtl/fpsr_dec.sv
module fpsr_dec
    import fpsr_pkg::*;
(
    input  fpsr_t cur,
    output logic  rnd_zero,
    output logic  flush_zero
);
    rnd_e mode;

    always_comb begin
        mode       = decode_rm(cur.rm);
        rnd_zero   = (mode == RND_ZERO);
        flush_zero = cur.dn;
    end
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
    import fpsr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [CSR_W-1:0]       wr_data,
    input  logic                   op_done,
    input  logic                   op_is_cmp,
    input  logic                   cmp_unordered,
    input  logic [NFLAG-1:0]       exc_flags,
    output logic [CSR_W-1:0]       csr_q,
    output logic                   rnd_zero,
    output logic                   flush_zero,
    output logic                   trap_req,
    output logic [TRAP_CODE_W-1:0] trap_code
);
    logic  op_apply;
    logic  hit;
    fpsr_t cur;

    assign op_apply = op_done && (!op_is_cmp || cmp_unordered);

    fpsr_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .op_apply (op_apply),
        .exc      (exc_flags),
        .cur      (cur),
        .trap_hit (hit)
    );

    fpsr_trap u_trap (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .trap_req  (trap_req),
        .trap_code (trap_code)
    );

    fpsr_dec u_dec (
        .cur        (cur),
        .rnd_zero   (rnd_zero),
        .flush_zero (flush_zero)
    );

    assign csr_q = cur;

    assert_trap_enabled_R6: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (|(cur.cause[NFLAG-1:0] & cur.en)));

    assert_trap_needs_exc_R6: assert property (@(posedge clk) disable iff (rst)
        (op_done && exc_flags == '0) |=> !trap_req);

    assert_cmp_ordered_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (op_done && op_is_cmp && !cmp_unordered && !wr_en) |=> ($stable(csr_q) && !trap_req));

    assert_write_merge_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_done) |=> cur.en == $past(wr_data[11:7]));

endmodule

// File: tb/sim_fpsr_unit.sv
module sim_fpsr_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        op_done;
    logic        op_is_cmp;
    logic        cmp_unordered;
    logic [4:0]  exc_flags;
    logic [31:0] csr_q;
    logic        rnd_zero;
    logic        flush_zero;
    logic        trap_req;
    logic [11:0] trap_code;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    fpsr_unit u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .op_done(op_done), .op_is_cmp(op_is_cmp), .cmp_unordered(cmp_unordered),
        .exc_flags(exc_flags), .csr_q(csr_q), .rnd_zero(rnd_zero),
        .flush_zero(flush_zero), .trap_req(trap_req), .trap_code(trap_code)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Drive for one clock edge, then release; outputs sampled 1 ns after the edge.
    task automatic cyc(bit w, logic [31:0] d, bit op, bit cmp, bit unord, logic [4:0] f);
        wr_en = w; wr_data = d; op_done = op; op_is_cmp = cmp;
        cmp_unordered = unord; exc_flags = f;
        @(posedge clk); #1;
        wr_en = 0; wr_data = '0; op_done = 0; op_is_cmp = 0;
        cmp_unordered = 0; exc_flags = '0;
    endtask

    task automatic t_reset;
        rst = 1;
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        rst = 0;
        chk("R1", "reset csr", csr_q, 0);
        chk("R1", "reset trap", trap_req, 0);
        chk("R2", "reset rnd", rnd_zero, 0);
        chk("R3", "reset flush", flush_zero, 0);
    endtask

    task automatic t_write_mask;
        cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0);
        chk("R1", "masked write", csr_q, 32'h0007_FFFF);
        chk("R2", "rm=11 nearest", rnd_zero, 0);
        chk("R3", "dn set", flush_zero, 1);
    endtask

    task automatic t_modes;
        cyc(1, 32'h1, 0, 0, 0, 0);
        chk("R2", "rm=01 to-zero", rnd_zero, 1);
        chk("R3", "dn clear", flush_zero, 0);
        cyc(1, 32'h2, 0, 0, 0, 0);
        chk("R2", "rm=10 nearest", rnd_zero, 0);
        cyc(1, 32'h0004_0000, 0, 0, 0, 0);
        chk("R2", "rm=00 nearest", rnd_zero, 0);
        chk("R3", "dn only", flush_zero, 1);
    endtask

    task automatic t_flags_cause;
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 5'b00101);
        chk("R4", "flags V|O", csr_q, 32'h5014);
        chk("R6", "no enable no trap", trap_req, 0);
        cyc(0, 0, 1, 0, 0, 5'b00000);
        chk("R5", "clean op keeps cause", csr_q, 32'h5000);
        cyc(0, 0, 1, 0, 0, 5'b10000);
        chk("R5", "cause accumulates I", csr_q, 32'h15040);
    endtask

    task automatic t_trap;
        cyc(1, 32'h100, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 5'b00010);
        chk("R6", "Z trap word", csr_q, 32'h2108);
        chk("R6", "Z trap req", trap_req, 1);
        chk("R6", "trap code", trap_code, 12'h120);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R6", "pulse ends", trap_req, 0);
        cyc(0, 0, 1, 0, 0, 5'b00000);
        chk("R6", "no exc no trap", trap_req, 0);
        chk("R4", "flags cleared", csr_q, 32'h2100);
        cyc(0, 0, 1, 0, 0, 5'b10000);
        chk("R6", "sticky cause traps", trap_req, 1);
        chk("R5", "word after I", csr_q, 32'h12140);
        cyc(1, 32'h80, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 5'b00100);
        chk("R6", "unenabled O no trap", trap_req, 0);
        chk("R5", "word after O", csr_q, 32'h4090);
    endtask

    task automatic t_compare;
        cyc(1, 32'h83, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 0, 5'b00001);
        chk("R7", "ordered cmp word", csr_q, 32'h83);
        chk("R7", "ordered cmp trap", trap_req, 0);
        cyc(1, 32'h80, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 1, 5'b00001);
        chk("R7", "unordered cmp word", csr_q, 32'h1084);
        chk("R7", "unordered cmp trap", trap_req, 1);
    endtask

    task automatic t_same_cycle;
        cyc(1, 32'h100, 1, 0, 0, 5'b00010);
        chk("R8", "write+op word", csr_q, 32'h2108);
        chk("R8", "written enable traps", trap_req, 1);
        cyc(1, 32'h0, 1, 0, 0, 5'b00001);
        chk("R8", "write clears enables word", csr_q, 32'h1004);
        chk("R8", "old enable ignored", trap_req, 0);
        cyc(1, 32'h0002_0000, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 5'b11111);
        chk("R5", "cause top bit kept", csr_q, 32'h3F07C);
    endtask

    initial begin
        wr_en = 0; wr_data = '0; op_done = 0; op_is_cmp = 0;
        cmp_unordered = 0; exc_flags = '0; rst = 1;
        t_reset();
        t_write_mask();
        t_modes();
        t_flags_cause();
        t_trap();
        t_compare();
        t_same_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule